// File: doc/BRIEF.md
# Configuration update handshake register target

This block is the register-side target of a voltage and frequency ramp controller. It presents a 32-bit register window on a simple single-master bus, one word per 4-byte step, with the last valid word at byte offset 0x68. Software uses the window in three ways. It writes configuration words into plain storage. It sets a root enable in the command word and then polls a busy flag until the flag reads zero. It runs a handshake on the update word: first it writes a selector number, then an enable bit. After a programmable delay the block answers with a one-hot acknowledge for that selector. The acknowledge stays set until software writes zero to the update word.

No real ramping is modelled. The busy flag and the acknowledge come from two countdown timers, set by the parameters `BUSY_CYCLES` and `ACK_CYCLES`. A read is answered exactly one cycle after it is issued. Writes to unmapped, misaligned or out-of-range addresses have no effect.

Top module: `ramp_cfg_target`

## Requirements
- R1: While reset is asserted no read response is given. After reset every register reads zero, including the command word at 0x00, the data words and the update word at 0x60.
- R2: The words at 0x10 to 0x38 and at 0x40 and 0x50 are plain read/write storage. Each holds all 32 written bits and reads back the last value written to it.
- R3: A write to an in-range offset that is neither storage nor a control word has no effect, and such an offset reads zero (0x04, 0x3C and 0x64 are examples). A write to an address above 0x68 has no effect and reads zero. So does a write to an address whose two low bits are not zero. None of these writes changes any other word.
- R4: In the command word, bit 1 is root enable and reads back the value last written to it. Bit 0 is busy and is read-only. A write with bit 1 set makes bit 0 read 1 for exactly `BUSY_CYCLES` cycles after that write, then 0.
- R5: A nonzero write to the update word ORs written bits 7:0 into the selector field (bits 7:0) and written bit 8 into the enable bit (bit 8). All other written bits are ignored, so successive writes accumulate.
- R6: When the enable bit goes from 0 to 1 with a latched selector N below 16, bit 16+N of the update word becomes 1 exactly `ACK_CYCLES` cycles after that write. Bits 31:16 are never more than one-hot.
- R7: When the enable bit rises with a selector of 16 or more, bits 31:16 stay zero.
- R8: Bits 31:16 stay set until a write of zero to the update word, and nonzero writes do not change them. A write of zero clears the whole word and cancels any acknowledge still pending.
- R9: If a write of zero to the update word lands in the same cycle in which an acknowledge would be set, the clear wins and the acknowledge never appears.
- R10: Every read request produces `bus_rvalid` high for one cycle, on the cycle after the request, with `bus_rdata` holding the word as it stood when the request was made. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | Read response strobe, one cycle after the read request |

## Verification
Two events can fall on the same clock edge: the acknowledge timer expiring and software writing zero to the update word. The bench arms the enable, counts idle cycles so that the clear write lands on exactly the cycle in which the acknowledge is due, and then reads the update word several times. Every read must return zero. If the set were allowed to win, the acknowledge bit would survive the clear. The bench also confirms that reads issued cycle by cycle around the busy and acknowledge deadlines see each change on exactly the predicted cycle.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned CMD_IDX   = 0;   // byte offset 0x00
  localparam int unsigned UPD_IDX   = 24;  // byte offset 0x60
  localparam int unsigned LAST_IDX  = 26;  // byte offset 0x68
  localparam int unsigned NUM_WORDS = LAST_IDX + 1;
  localparam int unsigned SEL_W     = 8;
  localparam int unsigned EN_BIT    = 8;
  localparam int unsigned ACK_W     = 16;
  localparam int unsigned ACK_SEL_W = $clog2(ACK_W);

  typedef struct packed {
    logic [ACK_W-1:0] ack;
    logic [6:0]       rsvd;
    logic             en;
    logic [SEL_W-1:0] sel;
  } upd_word_t;

  // storage words: 0x10..0x38, 0x40, 0x50
  function automatic logic is_data_word(int unsigned idx);
    return ((idx >= 4) && (idx <= 14)) || (idx == 16) || (idx == 20);
  endfunction
endpackage

// File: rtl/rc_rst_sync.sv
module rc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rc_data_bank.sv
module rc_data_bank
  import rc_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_word
);
  logic [NUM_WORDS-1:0][REG_W-1:0] words;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    if (is_data_word(i)) begin : g_store
      logic             word_we;
      logic [REG_W-1:0] word_q;

      assign word_we = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_q <= '0;
        else if (word_we) word_q <= wdata;
      end

      assign words[i] = word_q;
    end else begin : g_hole
      assign words[i] = '0;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (rd_idx == k[IDX_W-1:0]) rd_word = words[k];
    end
  end
endmodule

// File: rtl/rc_cmd_ctrl.sv
module rc_cmd_ctrl #(
  parameter int unsigned BUSY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_cmd,
  input  logic wdata_root,
  output logic root_en,
  output logic busy
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);

  logic             root_q, root_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    root_d = root_q;
    cnt_d  = (cnt_q != '0) ? cnt_q - CNT_W'(1) : cnt_q;
    if (wr_cmd) begin
      root_d = wdata_root;
      if (wdata_root) cnt_d = CNT_W'(BUSY_CYCLES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      root_q <= root_d;
      cnt_q  <= cnt_d;
    end
  end

  assign root_en = root_q;
  assign busy    = (cnt_q != '0);
endmodule

// File: rtl/rc_update_ctrl.sv
module rc_update_ctrl
  import rc_pkg::*;
#(
  parameter int unsigned ACK_CYCLES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_upd,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] upd_word
);
  localparam int unsigned CNT_W = $clog2(ACK_CYCLES + 1);

  upd_word_t        word_q, word_d;
  logic [SEL_W-1:0] lat_q, lat_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_clear, wr_set, lat_in_range;

  assign wr_clear     = wr_upd && (wdata == '0);
  assign wr_set       = wr_upd && !wr_clear;
  assign lat_in_range = (lat_q[SEL_W-1:ACK_SEL_W] == '0);

  always_comb begin
    word_d = word_q;
    lat_d  = lat_q;
    cnt_d  = (cnt_q != '0) ? cnt_q - CNT_W'(1) : cnt_q;

    // timer expiry: raise the one-hot acknowledge
    if ((cnt_q == CNT_W'(1)) && lat_in_range)
      word_d.ack = word_q.ack | (ACK_W'(1) << lat_q[ACK_SEL_W-1:0]);

    // accumulate selector and enable; a rising enable arms the timer
    if (wr_set) begin
      word_d.sel = word_q.sel | wdata[SEL_W-1:0];
      word_d.en  = word_q.en  | wdata[EN_BIT];
      if (!word_q.en && wdata[EN_BIT]) begin
        cnt_d = CNT_W'(ACK_CYCLES);
        lat_d = word_q.sel | wdata[SEL_W-1:0];
      end
    end

    // a zero write wins over everything above
    if (wr_clear) begin
      word_d = '0;
      lat_d  = '0;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      lat_q  <= '0;
      cnt_q  <= '0;
    end else begin
      word_q <= word_d;
      lat_q  <= lat_d;
      cnt_q  <= cnt_d;
    end
  end

  assign upd_word = word_q;
endmodule

// File: rtl/ramp_cfg_target.sv
module ramp_cfg_target
  import rc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BUSY_CYCLES = 4,
  parameter int unsigned ACK_CYCLES  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             rst_sync_n;
  logic [IDX_W-1:0] idx;
  logic [31:0]      idx_ext;
  logic             addr_ok, wr_hit, rd_hit, wr_cmd, wr_upd;
  logic             root_en, busy;
  logic [REG_W-1:0] cmd_word, upd_word, bank_word, rd_next;
  logic [REG_W-1:0] rdata_q;
  logic             rvalid_q;

  rc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign idx     = bus_addr[ADDR_W-1:2];
  assign idx_ext = {{(32-IDX_W){1'b0}}, idx};
  assign addr_ok = (bus_addr[1:0] == 2'b00) && (idx_ext <= LAST_IDX);
  assign wr_hit  = bus_req && bus_we && addr_ok;
  assign rd_hit  = bus_req && !bus_we;
  assign wr_cmd  = wr_hit && (idx_ext == CMD_IDX);
  assign wr_upd  = wr_hit && (idx_ext == UPD_IDX);

  rc_data_bank #(.IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_hit),
    .wr_idx  (idx),
    .wdata   (bus_wdata),
    .rd_idx  (idx),
    .rd_word (bank_word)
  );

  rc_cmd_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_cmd     (wr_cmd),
    .wdata_root (bus_wdata[1]),
    .root_en    (root_en),
    .busy       (busy)
  );

  rc_update_ctrl #(.ACK_CYCLES(ACK_CYCLES)) u_upd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_upd   (wr_upd),
    .wdata    (bus_wdata),
    .upd_word (upd_word)
  );

  // command word: bit 1 root enable, bit 0 busy
  assign cmd_word = {{(REG_W-2){1'b0}}, root_en, busy};

  always_comb begin
    rd_next = '0;
    if (addr_ok) begin
      if (idx_ext == CMD_IDX)      rd_next = cmd_word;
      else if (idx_ext == UPD_IDX) rd_next = upd_word;
      else                         rd_next = bank_word;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_hit;
      if (rd_hit) rdata_q <= rd_next;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;
endmodule

// File: rtl/rc_target_checker.sv
module rc_target_checker #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rvalid,
  input logic [31:0]       cmd_word,
  input logic [31:0]       upd_word
);
  logic rd_req, cmd_root_wr, upd_zero_wr;

  assign rd_req      = bus_req && !bus_we;
  assign cmd_root_wr = bus_req && bus_we && (bus_addr == ADDR_W'(0)) && bus_wdata[1];
  assign upd_zero_wr = bus_req && bus_we && (bus_addr == ADDR_W'(8'h60)) && (bus_wdata == 32'h0);

  p_read_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);

  p_no_stray_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);

  p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_root_wr |=> (cmd_word[1:0] == 2'b11));

  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_zero_wr |=> (upd_word == 32'h0));

  p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((upd_word[31:16] != 16'h0) && !upd_zero_wr) |=> $stable(upd_word[31:16]));

  p_ack_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_word[31:16]));
endmodule

bind ramp_cfg_target rc_target_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .cmd_word   (cmd_word),
  .upd_word   (upd_word)
);

// File: tb/test_ramp_cfg_target.sv
`timescale 1ns/1ps
module test_ramp_cfg_target;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned BUSY   = 4;
  localparam int unsigned ACKD   = 6;
  localparam logic [7:0]  A_CMD  = 8'h00;
  localparam logic [7:0]  A_UPD  = 8'h60;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rvalid;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  ramp_cfg_target #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY), .ACK_CYCLES(ACKD)) i_ramp_cfg_target (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 stray response", {31'b0, bus_rvalid}, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string       t = tag_q.pop_front();
        check(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    check(bus_rvalid === 1'b0, "R1 no response in reset", {31'b0, bus_rvalid}, 32'h0);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(A_CMD, 32'h0, "R1 cmd after reset");
    rd(8'h10, 32'h0, "R1 data after reset");
    rd(8'h50, 32'h0, "R1 data 0x50 after reset");
    rd(A_UPD, 32'h0, "R1 update after reset");

    // R2 storage
    wr(8'h10, 32'hA5A5_1234);
    wr(8'h2C, 32'h0000_8102);
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h38, 32'h0000_0111);
    wr(8'h40, 32'h000F_C987);
    wr(8'h50, 32'h0000_0C00);
    wr(8'h14, 32'h1111_1111);
    wr(8'h14, 32'hDEAD_BEEF);
    rd(8'h10, 32'hA5A5_1234, "R2 word 0x10");
    rd(8'h2C, 32'h0000_8102, "R2 word 0x2C");
    rd(8'h30, 32'hFFFF_FFFF, "R2 word 0x30");
    rd(8'h38, 32'h0000_0111, "R2 word 0x38");
    rd(8'h40, 32'h000F_C987, "R2 word 0x40");
    rd(8'h50, 32'h0000_0C00, "R2 word 0x50");
    rd(8'h14, 32'hDEAD_BEEF, "R2 overwrite 0x14");

    // R3 holes, out of range, misaligned
    wr(8'h04, 32'h1234_5678);
    wr(8'h3C, 32'h1234_5678);
    wr(8'h64, 32'h1234_5678);
    wr(8'h70, 32'h1234_5678);
    wr(8'h90, 32'h0BAD_0BAD);
    wr(8'h11, 32'h0BAD_0BAD);
    wr(8'h62, 32'h0000_0105);
    rd(8'h04, 32'h0, "R3 hole 0x04");
    rd(8'h3C, 32'h0, "R3 hole 0x3C");
    rd(8'h64, 32'h0, "R3 hole 0x64");
    rd(8'h70, 32'h0, "R3 above range 0x70");
    rd(8'h10, 32'hA5A5_1234, "R3 no alias from 0x90 or 0x11");
    rd(A_UPD, 32'h0, "R3 misaligned write to update ignored");

    // R4 root enable and busy window
    wr(A_CMD, 32'h2);
    for (int i = 0; i < 6; i++)
      rd(A_CMD, (i < BUSY) ? 32'h3 : 32'h2, "R4 busy window");
    wr(A_CMD, 32'h1);
    rd(A_CMD, 32'h0, "R4 busy bit not writable, root cleared");

    // R5 accumulation, R6 timed ack for selector 5
    wr(A_UPD, 32'h0000_0001);
    wr(A_UPD, 32'hFFFF_0004);
    rd(A_UPD, 32'h0000_0005, "R5 selector accumulates, upper bits ignored");
    wr(A_UPD, 32'h0000_0100);
    for (int i = 0; i < 8; i++)
      rd(A_UPD, (i < ACKD) ? 32'h0000_0105 : 32'h0020_0105, "R6 ack timing selector 5");
    idle(10);
    wr(A_UPD, 32'h0000_0100);
    rd(A_UPD, 32'h0020_0105, "R8 ack persists over nonzero write");
    wr(A_UPD, 32'h0);
    rd(A_UPD, 32'h0, "R8 zero write clears word");

    // R6 selector 0 and 15 in one write
    wr(A_UPD, 32'h0000_0100);
    idle(ACKD + 2);
    rd(A_UPD, 32'h0001_0100, "R6 selector 0 ack bit 16");
    wr(A_UPD, 32'h0);
    wr(A_UPD, 32'h0000_010F);
    idle(ACKD + 2);
    rd(A_UPD, 32'h8000_010F, "R6 selector 15 ack bit 31");
    wr(A_UPD, 32'h0);

    // R7 selector 16 gives no ack
    wr(A_UPD, 32'h0000_0110);
    idle(ACKD + 4);
    rd(A_UPD, 32'h0000_0110, "R7 selector 16 no ack");
    wr(A_UPD, 32'h0);

    // R8 clear while pending cancels
    wr(A_UPD, 32'h0000_0103);
    idle(2);
    wr(A_UPD, 32'h0);
    idle(ACKD + 2);
    rd(A_UPD, 32'h0, "R8 clear cancels pending ack");

    // R9 clear on the exact cycle of the ack
    wr(A_UPD, 32'h0000_0102);
    idle(ACKD - 1);
    wr(A_UPD, 32'h0);
    rd(A_UPD, 32'h0, "R9 clear wins collision");
    rd(A_UPD, 32'h0, "R9 clear wins collision next");
    idle(ACKD + 2);
    rd(A_UPD, 32'h0, "R9 no late ack");

    idle(3);
    check(exp_q.size() == 0, "R10 every read answered", exp_q.size(), 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule